// File: doc/BRIEF.md
# Serial Flash Probe and Capacity Discovery Sequencer

This block runs once after reset to bring up an attached SPI NOR flash. It drives the SPI pins itself (mode 0: clock idles low, data out changes on the falling edge, data in is sampled on the rising edge, most significant bit first). It reads the three identification bytes, applies a write-protection release for one vendor identity, waits for the device to report idle, then reads and checks the discoverable-parameter header and the basic parameter table it points to. From that table it derives the capacity of the device in bytes.

The result is a single ready or error indication plus the captured identification and byte size. A companion operation sequencer shares the same SPI pins and takes them over only once ready is high; until then, and forever after error, this block holds chip select high between its own transfers and idle after finishing.

Top module: `flash_probe_seq`

## Requirements
- R1: While reset is asserted and right after it, ready and error are 0, chip select is high (1) and the serial clock is low.
- R2: The first transfer is opcode 0x9F followed by three read bytes; the first byte received appears in dev_id[23:16], the second in dev_id[15:8], the third in dev_id[7:0].
- R3: When the first identification byte equals UNLOCK_ID (default 0xBF), the next two transfers are the single-byte commands 0x06 and then 0x98; for any other value neither is sent and the status poll follows directly.
- R4: The status register is read with opcode 0x05 (one read byte) repeatedly while its bit 0 is 1; when POLL_LIMIT reads in a row all return bit 0 set, error is raised and no further transfer starts.
- R5: After the status poll succeeds, one transfer of opcode 0x5A, a 3-byte address of 0x000000, one dummy byte and 16 read bytes is made.
- R6: The header is accepted only when its bytes 0..3 are 0x53 0x46 0x44 0x50, byte 5 is 0x01, byte 8 is 0x00 and byte 10 is 0x01; otherwise error is raised and the table is not read.
- R7: The table address is the little-endian value of header bytes 12 (least significant) to 14; it is sent most significant byte first after opcode 0x5A, followed by one dummy byte, and 8 bytes are read.
- R8: The table is accepted only when byte 0 bits [1:0] equal 2'b01, byte 1 equals 0x20, byte 2 bit 2 is 0 and byte 7 bit 7 is 0; otherwise error is raised.
- R9: On success, dev_bytes equals (D >> 3) + 1, where D is the little-endian 32-bit value of table bytes 4 (least significant) to 7, and it stays constant while ready is high.
- R10: Ready and error are never both high, each stays high until reset once set, and chip select stays high after either is set.
- R11: The serial clock is low whenever chip select is high and toggles only inside a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| ready | output | 1 | Device probed and accepted, sticky |
| error | output | 1 | Probe failed, sticky |
| dev_id | output | 24 | Identification bytes, first received in the top byte |
| dev_bytes | output | 32 | Device capacity in bytes |

## Verification
The hardest situation to reach is the status-poll timeout, together with the poll that succeeds on the very last allowed read, because it depends on how many times an attached device answers busy. The bench flash model answers busy for a programmable number of status reads, and the block is built with a small poll limit so that both the limit and one less than it are driven directly. Header and table faults are injected one field at a time into the model's parameter memory, while random table pointers with nonzero upper bytes expose byte-order errors in the address that is sent.

// File: rtl/probe_pkg.sv
package probe_pkg;

   localparam int HDR_BYTES = 16;
   localparam int TBL_BYTES = 8;

   localparam logic [7:0] OP_ID      = 8'h9F;
   localparam logic [7:0] OP_WEN     = 8'h06;
   localparam logic [7:0] OP_UNPROT  = 8'h98;
   localparam logic [7:0] OP_STATUS  = 8'h05;
   localparam logic [7:0] OP_PARAM   = 8'h5A;
   localparam logic [7:0] ERASE4K_OP = 8'h20;

   typedef enum logic [2:0] {
      ST_ID, ST_WEN, ST_UNPROT, ST_STATUS, ST_HDR, ST_TBL, ST_OK, ST_BAD
   } step_t;

   function automatic logic [7:0] byte_at(input logic [HDR_BYTES*8-1:0] b, input int i);
      return b[8*i +: 8];
   endfunction

   function automatic logic hdr_valid(input logic [HDR_BYTES*8-1:0] b);
      return byte_at(b, 0) == 8'h53 && byte_at(b, 1) == 8'h46 &&
             byte_at(b, 2) == 8'h44 && byte_at(b, 3) == 8'h50 &&
             byte_at(b, 5) == 8'h01 && byte_at(b, 8) == 8'h00 &&
             byte_at(b, 10) == 8'h01;
   endfunction

   function automatic logic tbl_valid(input logic [HDR_BYTES*8-1:0] b);
      return byte_at(b, 0) [1:0] == 2'b01 && byte_at(b, 1) == ERASE4K_OP &&
             !byte_at(b, 2) [2] && !byte_at(b, 7) [7];
   endfunction

   function automatic logic [31:0] capacity_bytes(input logic [HDR_BYTES*8-1:0] b);
      logic [31:0] dens;
      dens = {byte_at(b, 7), byte_at(b, 6), byte_at(b, 5), byte_at(b, 4)};
      return (dens >> 3) + 32'd1;
   endfunction

endpackage

// File: rtl/probe_spi_byte.sv
module probe_spi_byte #(
   parameter int HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic          busy;
   logic [7:0]    tsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         bitn <= '0;
         busy <= 1'b0;
         tsh  <= '0;
         sclk <= 1'b0;
         done <= 1'b0;
         rx   <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            tsh  <= tx;
            cnt  <= '0;
            bitn <= '0;
            sclk <= 1'b0;
         end else if (busy) begin
            if (cnt == CW'(HALF - 1)) begin
               cnt <= '0;
               if (!sclk) begin
                  sclk <= 1'b1;
                  rx   <= {rx[6:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (bitn == 3'd7) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bitn <= bitn + 3'd1;
                     tsh  <= {tsh[6:0], 1'b0};
                  end
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign mosi = tsh[7];
endmodule

// File: rtl/probe_txn.sv
module probe_txn #(
   parameter int HALF  = 2,
   parameter int GAP   = 2,
   parameter int RDMAX = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [7:0]                   op,
   input  logic [23:0]                  addr,
   input  logic                         addr_en,
   input  logic [$clog2(RDMAX+1)-1:0]   n_read,
   input  logic                         miso,
   output logic                         cs_n,
   output logic                         sclk,
   output logic                         mosi,
   output logic                         rx_we,
   output logic [$clog2(RDMAX)-1:0]     rx_idx,
   output logic [7:0]                   rx_byte,
   output logic                         done
);
   localparam int NW = $clog2(RDMAX + 1);
   localparam int IW = $clog2(RDMAX);
   localparam int PW = $clog2(RDMAX + 6);
   localparam int GW = $clog2(GAP + 1);

   typedef enum logic [1:0] {T_IDLE, T_LOAD, T_WAIT, T_GAP} tstate_t;

   tstate_t       ts;
   logic [PW-1:0] pos, first_rx, last_pos;
   logic [7:0]    op_q, tx_b;
   logic [23:0]   addr_q;
   logic          aen_q;
   logic [NW-1:0] nrd_q;
   logic [GW-1:0] gcnt;
   logic          b_done;
   logic [7:0]    b_rx;

   assign first_rx = aen_q ? PW'(5) : PW'(1);
   assign last_pos = first_rx + PW'(nrd_q) - PW'(1);

   always_comb begin
      tx_b = 8'h00;
      if (pos == '0)                         tx_b = op_q;
      else if (aen_q && pos == PW'(1))       tx_b = addr_q[23:16];
      else if (aen_q && pos == PW'(2))       tx_b = addr_q[15:8];
      else if (aen_q && pos == PW'(3))       tx_b = addr_q[7:0];
   end

   probe_spi_byte #(.HALF(HALF)) u_byte (
      .clk(clk), .rst_n(rst_n), .start(ts == T_LOAD), .tx(tx_b), .miso(miso),
      .sclk(sclk), .mosi(mosi), .done(b_done), .rx(b_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts      <= T_IDLE;
         pos     <= '0;
         op_q    <= '0;
         addr_q  <= '0;
         aen_q   <= 1'b0;
         nrd_q   <= '0;
         gcnt    <= '0;
         cs_n    <= 1'b1;
         rx_we   <= 1'b0;
         rx_idx  <= '0;
         rx_byte <= '0;
         done    <= 1'b0;
      end else begin
         rx_we <= 1'b0;
         done  <= 1'b0;
         case (ts)
            T_IDLE: if (start) begin
               op_q   <= op;
               addr_q <= addr;
               aen_q  <= addr_en;
               nrd_q  <= n_read;
               pos    <= '0;
               cs_n   <= 1'b0;
               ts     <= T_LOAD;
            end
            T_LOAD: ts <= T_WAIT;
            T_WAIT: if (b_done) begin
               if (pos >= first_rx) begin
                  rx_we   <= 1'b1;
                  rx_idx  <= IW'(pos - first_rx);
                  rx_byte <= b_rx;
               end
               if (pos == last_pos) begin
                  cs_n <= 1'b1;
                  gcnt <= '0;
                  ts   <= T_GAP;
               end else begin
                  pos <= pos + PW'(1);
                  ts  <= T_LOAD;
               end
            end
            T_GAP: begin
               if (gcnt == GW'(GAP - 1)) begin
                  done <= 1'b1;
                  ts   <= T_IDLE;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: ts <= T_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/probe_capture.sv
module probe_capture #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] idx,
   input  logic [7:0]               din,
   output logic [DEPTH*8-1:0]       flat
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flat[8*g +: 8] <= '0;
         else if (we && idx == ($clog2(DEPTH))'(g))
            flat[8*g +: 8] <= din;
      end
   end
endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
   import probe_pkg::*;
#(
   parameter int         CLK_HALF   = 2,
   parameter int         CS_GAP     = 2,
   parameter int         POLL_LIMIT = 1000,
   parameter logic [7:0] UNLOCK_ID  = 8'hBF
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        spi_cs_n,
   output logic        spi_sclk,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic        ready,
   output logic        error,
   output logic [23:0] dev_id,
   output logic [31:0] dev_bytes
);
   localparam int NW  = $clog2(HDR_BYTES + 1);
   localparam int IW  = $clog2(HDR_BYTES);
   localparam int PCW = $clog2(POLL_LIMIT + 1);

   initial begin
      assert (CLK_HALF >= 1) else $error("CLK_HALF must be at least 1");
      assert (CS_GAP >= 1) else $error("CS_GAP must be at least 1");
      assert (POLL_LIMIT >= 1) else $error("POLL_LIMIT must be at least 1");
   end

   step_t                 st;
   logic                  issued;
   logic                  t_start, t_done, t_aen, rx_we;
   logic [7:0]            t_op, rx_byte;
   logic [23:0]           t_addr, tbl_ptr;
   logic [NW-1:0]         t_nrd;
   logic [IW-1:0]         rx_idx;
   logic [HDR_BYTES*8-1:0] cap;
   logic [PCW-1:0]        polls;

   always_comb begin
      t_op   = OP_ID;
      t_addr = '0;
      t_aen  = 1'b0;
      t_nrd  = '0;
      case (st)
         ST_ID:     begin t_op = OP_ID;     t_nrd = NW'(3); end
         ST_WEN:    t_op = OP_WEN;
         ST_UNPROT: t_op = OP_UNPROT;
         ST_STATUS: begin t_op = OP_STATUS; t_nrd = NW'(1); end
         ST_HDR:    begin t_op = OP_PARAM;  t_aen = 1'b1; t_nrd = NW'(HDR_BYTES); end
         ST_TBL:    begin t_op = OP_PARAM;  t_aen = 1'b1; t_addr = tbl_ptr; t_nrd = NW'(TBL_BYTES); end
         default:   ;
      endcase
   end

   assign t_start = !issued && st != ST_OK && st != ST_BAD;

   probe_txn #(.HALF(CLK_HALF), .GAP(CS_GAP), .RDMAX(HDR_BYTES)) u_txn (
      .clk(clk), .rst_n(rst_n), .start(t_start), .op(t_op), .addr(t_addr),
      .addr_en(t_aen), .n_read(t_nrd), .miso(spi_miso), .cs_n(spi_cs_n),
      .sclk(spi_sclk), .mosi(spi_mosi), .rx_we(rx_we), .rx_idx(rx_idx),
      .rx_byte(rx_byte), .done(t_done)
   );

   probe_capture #(.DEPTH(HDR_BYTES)) u_cap (
      .clk(clk), .rst_n(rst_n), .we(rx_we), .idx(rx_idx), .din(rx_byte), .flat(cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_ID;
         issued    <= 1'b0;
         polls     <= '0;
         tbl_ptr   <= '0;
         ready     <= 1'b0;
         error     <= 1'b0;
         dev_id    <= '0;
         dev_bytes <= '0;
      end else begin
         if (t_start) issued <= 1'b1;
         if (t_done) begin
            issued <= 1'b0;
            case (st)
               ST_ID: begin
                  dev_id <= {byte_at(cap, 0), byte_at(cap, 1), byte_at(cap, 2)};
                  st     <= (byte_at(cap, 0) == UNLOCK_ID) ? ST_WEN : ST_STATUS;
               end
               ST_WEN:    st <= ST_UNPROT;
               ST_UNPROT: st <= ST_STATUS;
               ST_STATUS: begin
                  if (!cap[0]) begin
                     st <= ST_HDR;
                  end else if (polls == PCW'(POLL_LIMIT - 1)) begin
                     st    <= ST_BAD;
                     error <= 1'b1;
                  end else begin
                     polls <= polls + 1'b1;
                  end
               end
               ST_HDR: begin
                  if (hdr_valid(cap)) begin
                     tbl_ptr <= {byte_at(cap, 14), byte_at(cap, 13), byte_at(cap, 12)};
                     st      <= ST_TBL;
                  end else begin
                     st    <= ST_BAD;
                     error <= 1'b1;
                  end
               end
               ST_TBL: begin
                  if (tbl_valid(cap)) begin
                     dev_bytes <= capacity_bytes(cap);
                     st        <= ST_OK;
                     ready     <= 1'b1;
                  end else begin
                     st    <= ST_BAD;
                     error <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/probe_chk.sv
module probe_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        spi_cs_n,
   input logic        spi_sclk,
   input logic        ready,
   input logic        error,
   input logic [23:0] dev_id,
   input logic [31:0] dev_bytes
);
   p_ready_error_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && error));

   p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   p_error_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);

   p_cs_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ready || error) |-> spi_cs_n);

   p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   p_result_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ($stable(dev_bytes) && $stable(dev_id)));
endmodule

bind flash_probe_seq probe_chk u_chk (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
   .ready(ready), .error(error), .dev_id(dev_id), .dev_bytes(dev_bytes)
);

// File: tb/sim_flash_probe_seq.sv
module sim_flash_probe_seq;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_cs_n, spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;
   logic        ready, error;
   logic [23:0] dev_id;
   logic [31:0] dev_bytes;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_probe_seq #(.POLL_LIMIT(LIMIT)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ready(ready), .error(error),
      .dev_id(dev_id), .dev_bytes(dev_bytes)
   );

   // ---------------- flash model ----------------
   logic [7:0]  mem [256];
   logic [7:0]  m_id [3];
   int          wip_reads = 0;
   int          stat_reads = 0;
   int          bit_cnt = 0, byte_idx = 0, n_ops = 0, viol = 0;
   logic [7:0]  in_sh = 0, out_sh = 0, nxt = 0, cur_op = 0;
   logic [23:0] cur_addr = 0;
   bit          load = 0;
   logic [7:0]  op_log [32];
   logic [23:0] adr_log [32];
   int          nb_log [32];

   function automatic logic [7:0] resp(input int k);
      case (cur_op)
         8'h9F:   return (k >= 1 && k <= 3) ? m_id[k-1] : 8'h00;
         8'h05:   return (stat_reads < wip_reads) ? 8'hA5 : 8'hA4;
         8'h5A:   return (k >= 5) ? mem[8'(cur_addr[7:0] + 8'(k - 5))] : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   always @(negedge spi_cs_n) begin
      bit_cnt = 0; byte_idx = 0; out_sh = 0; spi_miso = 1'b0; load = 0;
   end

   always @(posedge spi_sclk) begin
      if (spi_cs_n) viol++;
      else begin
         in_sh = {in_sh[6:0], spi_mosi};
         bit_cnt++;
         if (bit_cnt == 8) begin
            bit_cnt = 0;
            if (byte_idx == 0) cur_op = in_sh;
            else if (byte_idx <= 3) cur_addr = {cur_addr[15:0], in_sh};
            byte_idx++;
            nxt  = resp(byte_idx);
            load = 1;
         end
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         if (load) begin out_sh = nxt; load = 0; end
         else out_sh = {out_sh[6:0], 1'b0};
         spi_miso = out_sh[7];
      end
   end

   always @(posedge spi_cs_n) begin
      if (byte_idx > 0 && n_ops < 32) begin
         op_log[n_ops]  = cur_op;
         adr_log[n_ops] = cur_addr;
         nb_log[n_ops]  = byte_idx;
         n_ops++;
         if (cur_op == 8'h05) stat_reads++;
      end
      byte_idx = 0;
   end

   // ---------------- checking helpers ----------------
   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_size(input logic [31:0] dens);
      return (dens >> 3) + 32'd1;
   endfunction

   // fault: 0 none, 1..4 header fields, 5..8 table fields
   task automatic run(input logic [7:0] id0, input int wip_n, input int fault,
                      input logic [23:0] ptr, input logic [31:0] dens);
      logic [7:0] pl;
      bit timeout, hdr_good, tbl_good, ok, unl;
      int nstat, exp_ops, k, w;
      logic [31:0] d;
      d = {1'b0, dens[30:0]};
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      m_id[0] = id0; m_id[1] = 8'($urandom); m_id[2] = 8'($urandom);
      mem[0] = 8'h53; mem[1] = 8'h46; mem[2] = 8'h44; mem[3] = 8'h50;
      mem[5] = 8'h01; mem[8] = 8'h00; mem[10] = 8'h01;
      mem[12] = ptr[7:0]; mem[13] = ptr[15:8]; mem[14] = ptr[23:16];
      pl = ptr[7:0];
      mem[pl]   = {6'($urandom), 2'b01};
      mem[pl+1] = 8'h20;
      mem[pl+2] = 8'($urandom) & 8'hFB;
      mem[pl+4] = d[7:0]; mem[pl+5] = d[15:8]; mem[pl+6] = d[23:16]; mem[pl+7] = d[31:24];
      case (fault)
         1: mem[2] = 8'h45;
         2: mem[5] = 8'h02;
         3: mem[8] = 8'h01;
         4: mem[10] = 8'h00;
         5: mem[pl] = mem[pl] | 8'h03;
         6: mem[pl+1] = 8'hD8;
         7: mem[pl+2] = mem[pl+2] | 8'h04;
         8: mem[pl+7] = mem[pl+7] | 8'h80;
         default: ;
      endcase
      wip_reads = wip_n; stat_reads = 0; n_ops = 0; viol = 0;

      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(!ready && !error && spi_cs_n && !spi_sclk, "R1 reset state",
            {ready, error, spi_cs_n, spi_sclk}, 4'b0010);
      rst_n = 1'b1;

      w = 0;
      while (!ready && !error && w < 40000) begin @(negedge clk); w++; end
      check(w < 40000, "R10 completion", w, 0);

      timeout  = (wip_n >= LIMIT);
      hdr_good = !(fault >= 1 && fault <= 4);
      tbl_good = !(fault >= 5 && fault <= 8);
      ok       = !timeout && hdr_good && tbl_good;
      unl      = (id0 == 8'hBF);
      nstat    = timeout ? LIMIT : wip_n + 1;
      exp_ops  = 1 + (unl ? 2 : 0) + nstat + (timeout ? 0 : 1) + ((timeout || !hdr_good) ? 0 : 1);

      check(ready == ok && error == !ok, "R6 R8 outcome", {ready, error}, {ok, !ok});
      check(op_log[0] == 8'h9F && nb_log[0] == 4, "R2 id opcode", op_log[0], 8'h9F);
      check(dev_id == {id0, m_id[1], m_id[2]}, "R2 id value", dev_id, {id0, m_id[1], m_id[2]});
      if (unl)
         check(op_log[1] == 8'h06 && op_log[2] == 8'h98 && nb_log[1] == 1 && nb_log[2] == 1,
               "R3 unlock pair", {op_log[1], op_log[2]}, 16'h0698);
      else
         check(op_log[1] == 8'h05, "R3 no unlock", op_log[1], 8'h05);
      check(n_ops == exp_ops, "R4 transfer count", n_ops, exp_ops);
      k = unl ? 3 : 1;
      for (int i = 0; i < nstat; i++)
         check(op_log[k+i] == 8'h05 && nb_log[k+i] == 2, "R4 status poll", op_log[k+i], 8'h05);
      k = k + nstat;
      if (!timeout)
         check(op_log[k] == 8'h5A && adr_log[k] == 24'h0 && nb_log[k] == 21,
               "R5 header read", {op_log[k], adr_log[k]}, 32'h5A000000);
      if (!timeout && hdr_good)
         check(op_log[k+1] == 8'h5A && adr_log[k+1] == ptr && nb_log[k+1] == 13,
               "R7 table read", adr_log[k+1], ptr);
      if (ok)
         check(dev_bytes == exp_size(d), "R9 size", dev_bytes, exp_size(d));

      w = n_ops;
      repeat (60) @(negedge clk);
      check(ready == ok && error == !ok && spi_cs_n && n_ops == w, "R10 sticky idle",
            {ready, error, spi_cs_n}, {ok, !ok, 1'b1});
      check(viol == 0, "R11 clock only with select", viol, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // directed corners
      run(8'hBF, 0, 0, 24'h000030, 32'h00FF_FFFF);
      run(8'hC2, 2, 0, 24'hA1B2C4, 32'h7FFF_FFFF);
      run(8'hEF, 0, 0, 24'h123410, 32'h0000_0000);
      run(8'h20, LIMIT - 1, 0, 24'h000040, 32'h03FF_FFFF);
      run(8'h20, LIMIT, 0, 24'h000040, 32'h03FF_FFFF);
      run(8'hBF, LIMIT + 3, 0, 24'h000040, 32'h03FF_FFFF);
      for (int f = 1; f <= 8; f++)
         run(8'h9D, 1, f, 24'h5600A0, 32'h01FF_FFFF);
      // random mix
      for (int n = 0; n < 14; n++) begin
         logic [7:0] idr;
         int wr, fr;
         idr = ($urandom % 3 == 0) ? 8'hBF : 8'($urandom);
         wr  = $urandom % (LIMIT + 2);
         fr  = ($urandom % 2 == 0) ? 0 : int'($urandom % 9);
         run(idr, wr, fr, {16'($urandom), 8'(16 + $urandom % 224)}, $urandom);
      end
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule